// File: doc/BRIEF.md
# Two-Ring Urgency Command Fetcher

This block sits on the device side of a host-to-storage command path. The host keeps two submission rings in its memory. One ring holds latency-critical commands and the other holds bulk-throughput commands. The host announces new work by writing the new tail index of a ring to that ring's doorbell. For each ring the block keeps a fetch pointer (head) and a tail. It picks the ring to serve next and issues one read at a time on a memory-read port. When the read returns, the block hands the command to a downstream executor, tagged with the ring it came from.

Latency work always wins the pick. Throughput reads wait while any latency entry is still unfetched. The only exception is a configurable anti-starvation rule, which forces one throughput fetch after a run of consecutive latency fetches.

When the executor finishes a command, the block writes a completion entry into one shared completion ring. The host frees completion slots with a head doorbell. It finds new entries by polling a phase bit, and the block raises no interrupt.

Top module: `cmd_fetch_arb`

## Requirements
- R1: After reset, `rd_req_valid`, `cmd_valid`, `cq_wr_en` and `err_overflow` are low and `cpl_ready` is high.
- R2: A doorbell is a one-cycle `db_wr_en` with `db_sel` 0 (latency tail), 1 (throughput tail) or 2 (completion head); code 3 does nothing. If an idle block accepts a tail doorbell in clock edge E, it raises `rd_req_valid` for exactly one cycle after edge E+1. The address is the ring base plus the head index.
- R3: When the block is idle and both rings have unfetched entries, it fetches from the latency ring, unless R8 applies.
- R4: No new read request is issued while an earlier one has not yet been answered on `rd_rsp_valid`.
- R5: The cycle after a response is taken, `cmd_valid` pulses for one cycle. `cmd_data` equals the returned data, and `cmd_ring` is 0 for the latency ring and 1 for the throughput ring.
- R6: A tail doorbell that would advance the tail past the head is ignored, so no extra fetch happens. It also sets `err_overflow`, which stays high until reset.
- R7: A ring of DEPTH slots accepts DEPTH-1 outstanding entries without raising `err_overflow`.
- R8: With STARVE_LIMIT = N > 0, after N consecutive latency fetches with a throughput entry waiting, the next fetch comes from the throughput ring.
- R9: With STARVE_LIMIT = 0, the latency ring is always drained before any throughput fetch.
- R10: A completion accepted at edge E (`cpl_valid` and `cpl_ready`) appears as a one-cycle `cq_wr_en` after E. The address is the completion base plus the tail index. The data is {phase, ring, current head of that ring, tag}, from most significant to least significant bit.
- R11: The phase bit starts at 1 and inverts each time the completion tail wraps from DEPTH-1 to 0.
- R12: `cpl_ready` is low when the completion tail is one slot behind its head. A completion offered then is not written. A head doorbell that advances the head raises `cpl_ready` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_sel | input | 2 | Doorbell target: 0 latency tail, 1 throughput tail, 2 completion head |
| db_value | input | IDX_W | New index written by the doorbell |
| rd_req_valid | output | 1 | Command read request pulse |
| rd_req_addr | output | ADDR_W | Entry address of the read |
| rd_rsp_valid | input | 1 | Read data return strobe |
| rd_rsp_data | input | CMD_W | Returned command |
| cmd_valid | output | 1 | Command handed to executor |
| cmd_data | output | CMD_W | Command payload |
| cmd_ring | output | 1 | Source ring of the command (0 latency, 1 throughput) |
| cpl_valid | input | 1 | Executor reports a finished command |
| cpl_ring | input | 1 | Ring of the finished command |
| cpl_tag | input | TAG_W | Identifier of the finished command |
| cpl_ready | output | 1 | Completion ring has room |
| cq_wr_en | output | 1 | Completion entry write strobe |
| cq_wr_addr | output | ADDR_W | Completion entry address |
| cq_wr_data | output | CQE_W | Completion entry {phase, ring, head, tag} |
| err_overflow | output | 1 | Sticky flag for a rejected doorbell |

## Verification
The interesting overlap is a latency doorbell that arrives while a throughput read is still in flight. The response and the new pending latency entry then meet in one decision cycle. The bench provokes this by writing the throughput doorbell and then the latency doorbell on back-to-back writes. It judges the case by comparing the full logged command order against an order computed from ring indices and the starvation limit. A second overlap is a completion offered in the same cycles in which the completion ring is full and then freed by a head doorbell. It is judged by the entries written and by when `cpl_ready` changes.

// File: rtl/cfa_pkg.sv
`timescale 1ns/1ps
package cfa_pkg;
    typedef enum logic [1:0] {
        DB_LAT_TAIL = 2'd0,
        DB_THR_TAIL = 2'd1,
        DB_CQ_HEAD  = 2'd2,
        DB_UNUSED   = 2'd3
    } db_sel_e;

    typedef enum logic {
        RING_LAT = 1'b0,
        RING_THR = 1'b1
    } ring_e;
endpackage

// File: rtl/cfa_sq_ring.sv
`timescale 1ns/1ps
// Head/tail bookkeeping for one submission ring with doorbell validation.
module cfa_sq_ring #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_we,
    input  logic [IDX_W-1:0] db_tail,
    input  logic             fetch_done,
    output logic [IDX_W-1:0] head_o,
    output logic             pending_o,
    output logic             reject_o
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [IDX_W-1:0] room_w;
    logic [IDX_W-1:0] step_w;

    always_comb begin
        st_d     = st_q;
        reject_o = 1'b0;
        // free slots before the tail would run into the head
        room_w   = st_q.head - st_q.tail - 1'b1;
        step_w   = db_tail - st_q.tail;
        if (db_we) begin
            if (step_w > room_w) begin
                reject_o = 1'b1;
            end else begin
                st_d.tail = db_tail;
            end
        end
        if (fetch_done) begin
            st_d.head = st_q.head + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o    = st_q.head;
    assign pending_o = (st_q.head != st_q.tail);
endmodule

// File: rtl/cfa_starve_guard.sv
`timescale 1ns/1ps
// Counts consecutive latency fetches; forces a throughput pick at the limit.
module cfa_starve_guard #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lat_done,
    input  logic thr_done,
    input  logic thr_pend,
    output logic force_thr
);
    generate
        if (LIMIT > 0) begin : g_on
            localparam int CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] LIM = CW'(LIMIT);
            logic [CW-1:0] run_d, run_q;

            always_comb begin
                run_d = run_q;
                if (thr_done) begin
                    run_d = '0;
                end else if (lat_done && (run_q != LIM)) begin
                    run_d = run_q + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= '0;
                end else begin
                    run_q <= run_d;
                end
            end

            assign force_thr = thr_pend && (run_q == LIM);
        end else begin : g_off
            assign force_thr = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfa_fetch_arb.sv
`timescale 1ns/1ps
// Picks a ring, keeps a single read in flight, forwards returned commands.
module cfa_fetch_arb
    import cfa_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 16,
    parameter int CMD_W  = 32,
    parameter logic [ADDR_W-1:0] LAT_BASE = '0,
    parameter logic [ADDR_W-1:0] THR_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_pend,
    input  logic              thr_pend,
    input  logic [IDX_W-1:0]  lat_head,
    input  logic [IDX_W-1:0]  thr_head,
    input  logic              force_thr,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [CMD_W-1:0]  rd_rsp_data,
    output logic              lat_done,
    output logic              thr_done,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              cmd_ring
);
    typedef struct packed {
        logic              busy;
        ring_e             sel;
        logic              req_v;
        logic [ADDR_W-1:0] req_addr;
        logic              cmd_v;
        logic [CMD_W-1:0]  cmd_data;
        ring_e             cmd_ring;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.req_v = 1'b0;
        st_d.cmd_v = 1'b0;
        lat_done   = st_q.busy && rd_rsp_valid && (st_q.sel == RING_LAT);
        thr_done   = st_q.busy && rd_rsp_valid && (st_q.sel == RING_THR);
        if (!st_q.busy) begin
            if (thr_pend && (force_thr || !lat_pend)) begin
                st_d.busy     = 1'b1;
                st_d.sel      = RING_THR;
                st_d.req_v    = 1'b1;
                st_d.req_addr = THR_BASE + ADDR_W'(thr_head);
            end else if (lat_pend) begin
                st_d.busy     = 1'b1;
                st_d.sel      = RING_LAT;
                st_d.req_v    = 1'b1;
                st_d.req_addr = LAT_BASE + ADDR_W'(lat_head);
            end
        end else if (rd_rsp_valid) begin
            st_d.busy     = 1'b0;
            st_d.cmd_v    = 1'b1;
            st_d.cmd_data = rd_rsp_data;
            st_d.cmd_ring = st_q.sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_req_valid = st_q.req_v;
    assign rd_req_addr  = st_q.req_addr;
    assign cmd_valid    = st_q.cmd_v;
    assign cmd_data     = st_q.cmd_data;
    assign cmd_ring     = st_q.cmd_ring;
endmodule

// File: rtl/cfa_cq_post.sv
`timescale 1ns/1ps
// Shared completion ring: entry writes, phase tracking, head doorbell.
module cfa_cq_post #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CQ_BASE = '0,
    localparam int ENT_W = 2 + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic              cpl_ring,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [IDX_W-1:0]  lat_head,
    input  logic [IDX_W-1:0]  thr_head,
    input  logic              hd_we,
    input  logic [IDX_W-1:0]  hd_val,
    output logic              cpl_ready,
    output logic              cq_wr_en,
    output logic [ADDR_W-1:0] cq_wr_addr,
    output logic [ENT_W-1:0]  cq_wr_data,
    output logic              reject_o
);
    typedef struct packed {
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic              phase;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [ENT_W-1:0]  wr_data;
    } cq_st_t;

    cq_st_t st_d, st_q;
    logic [IDX_W-1:0] tail_inc_w;
    logic [IDX_W-1:0] used_w;
    logic [IDX_W-1:0] step_w;
    logic [IDX_W-1:0] src_head_w;
    logic             full_w;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        reject_o   = 1'b0;
        tail_inc_w = st_q.tail + 1'b1;
        full_w     = (tail_inc_w == st_q.head);
        used_w     = st_q.tail - st_q.head;
        step_w     = hd_val - st_q.head;
        src_head_w = cpl_ring ? thr_head : lat_head;
        if (cpl_valid && !full_w) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = CQ_BASE + ADDR_W'(st_q.tail);
            st_d.wr_data = {st_q.phase, cpl_ring, src_head_w, cpl_tag};
            st_d.tail    = tail_inc_w;
            if (st_q.tail == '1) begin
                st_d.phase = ~st_q.phase;
            end
        end
        if (hd_we) begin
            if (step_w > used_w) begin
                reject_o = 1'b1;
            end else begin
                st_d.head = hd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpl_ready  = !full_w;
    assign cq_wr_en   = st_q.wr_en;
    assign cq_wr_addr = st_q.wr_addr;
    assign cq_wr_data = st_q.wr_data;
endmodule

// File: rtl/cmd_fetch_arb.sv
`timescale 1ns/1ps
module cmd_fetch_arb
    import cfa_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int ADDR_W       = 16,
    parameter int CMD_W        = 32,
    parameter int TAG_W        = 8,
    parameter int STARVE_LIMIT = 64,
    parameter logic [ADDR_W-1:0] LAT_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] THR_BASE = 16'h0200,
    parameter logic [ADDR_W-1:0] CQ_BASE  = 16'h0300,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CQE_W = 2 + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_wr_en,
    input  logic [1:0]        db_sel,
    input  logic [IDX_W-1:0]  db_value,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [CMD_W-1:0]  rd_rsp_data,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              cmd_ring,
    input  logic              cpl_valid,
    input  logic              cpl_ring,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic              cpl_ready,
    output logic              cq_wr_en,
    output logic [ADDR_W-1:0] cq_wr_addr,
    output logic [CQE_W-1:0]  cq_wr_data,
    output logic              err_overflow
);
    db_sel_e          sel_w;
    logic             we_lat, we_thr, we_cq;
    logic             lat_pend, thr_pend;
    logic [IDX_W-1:0] lat_head, thr_head;
    logic             rej_lat, rej_thr, rej_cq;
    logic             lat_done, thr_done, force_thr;
    logic             err_d, err_q;

    always_comb begin
        sel_w  = db_sel_e'(db_sel);
        we_lat = db_wr_en && (sel_w == DB_LAT_TAIL);
        we_thr = db_wr_en && (sel_w == DB_THR_TAIL);
        we_cq  = db_wr_en && (sel_w == DB_CQ_HEAD);
        err_d  = err_q | rej_lat | rej_thr | rej_cq;
    end

    cfa_sq_ring #(.IDX_W(IDX_W)) u_lat_ring (
        .clk(clk), .rst_n(rst_n), .db_we(we_lat), .db_tail(db_value),
        .fetch_done(lat_done), .head_o(lat_head), .pending_o(lat_pend),
        .reject_o(rej_lat)
    );

    cfa_sq_ring #(.IDX_W(IDX_W)) u_thr_ring (
        .clk(clk), .rst_n(rst_n), .db_we(we_thr), .db_tail(db_value),
        .fetch_done(thr_done), .head_o(thr_head), .pending_o(thr_pend),
        .reject_o(rej_thr)
    );

    cfa_starve_guard #(.LIMIT(STARVE_LIMIT)) u_guard (
        .clk(clk), .rst_n(rst_n), .lat_done(lat_done), .thr_done(thr_done),
        .thr_pend(thr_pend), .force_thr(force_thr)
    );

    cfa_fetch_arb #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W),
        .LAT_BASE(LAT_BASE), .THR_BASE(THR_BASE)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .lat_pend(lat_pend), .thr_pend(thr_pend),
        .lat_head(lat_head), .thr_head(thr_head), .force_thr(force_thr),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .lat_done(lat_done), .thr_done(thr_done), .cmd_valid(cmd_valid),
        .cmd_data(cmd_data), .cmd_ring(cmd_ring)
    );

    cfa_cq_post #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CQ_BASE(CQ_BASE)
    ) u_cq (
        .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ring(cpl_ring),
        .cpl_tag(cpl_tag), .lat_head(lat_head), .thr_head(thr_head),
        .hd_we(we_cq), .hd_val(db_value), .cpl_ready(cpl_ready),
        .cq_wr_en(cq_wr_en), .cq_wr_addr(cq_wr_addr), .cq_wr_data(cq_wr_data),
        .reject_o(rej_cq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_overflow = err_q;
endmodule

// File: rtl/cfa_checker.sv
`timescale 1ns/1ps
module cfa_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_req_valid,
    input logic rd_rsp_valid,
    input logic cmd_valid,
    input logic err_overflow,
    input logic cpl_valid,
    input logic cpl_ready,
    input logic cq_wr_en
);
    logic inflight_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
        end else if (rd_req_valid) begin
            inflight_q <= 1'b1;
        end else if (rd_rsp_valid) begin
            inflight_q <= 1'b0;
        end
    end

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid); // R2
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !inflight_q); // R4
    AST_CMD_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rsp_valid && inflight_q) |=> cmd_valid); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow); // R6
    AST_CPL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> cq_wr_en); // R10
    AST_CPL_BLOCKED_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> !cq_wr_en); // R12
endmodule

bind cmd_fetch_arb cfa_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid),
    .rd_rsp_valid(rd_rsp_valid), .cmd_valid(cmd_valid),
    .err_overflow(err_overflow), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cq_wr_en(cq_wr_en)
);

// File: tb/cmd_fetch_arb_tb_top.sv
`timescale 1ns/1ps
// Read-port stand-in: answers one cycle after a request unless held.
module cfa_rdport_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold,
    input  logic        req_valid,
    input  logic [15:0] req_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    logic        pend;
    logic [15:0] paddr;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; paddr <= '0; rsp_valid <= 1'b0; rsp_data <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_valid) begin
                pend <= 1'b1; paddr <= req_addr;
            end else if (pend && !hold) begin
                pend <= 1'b0; rsp_valid <= 1'b1; rsp_data <= {paddr, ~paddr};
            end
        end
    end
endmodule

module cmd_fetch_arb_tb_top;
    localparam logic [15:0] LB = 16'h0100, TB = 16'h0200, CB = 16'h0300;

    logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0;
    logic db_wr_en = 1'b0;
    logic [1:0] db_sel = 2'd0;
    logic [3:0] db_value = 4'd0;
    logic cpl_valid = 1'b0, cpl_ring = 1'b0;
    logic [7:0] cpl_tag = 8'd0;

    logic a_req, a_rsp, a_cmd, a_ring, a_cready, a_cqwe, a_err;
    logic [15:0] a_raddr, a_cqaddr;
    logic [31:0] a_rdata, a_cdata;
    logic [13:0] a_cqdata;
    logic b_req, b_rsp, b_cmd, b_ring, b_cready, b_cqwe, b_err;
    logic [15:0] b_raddr, b_cqaddr;
    logic [31:0] b_rdata, b_cdata;
    logic [13:0] b_cqdata;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmd_fetch_arb #(.STARVE_LIMIT(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .db_wr_en(db_wr_en), .db_sel(db_sel),
        .db_value(db_value), .rd_req_valid(a_req), .rd_req_addr(a_raddr),
        .rd_rsp_valid(a_rsp), .rd_rsp_data(a_rdata), .cmd_valid(a_cmd),
        .cmd_data(a_cdata), .cmd_ring(a_ring), .cpl_valid(cpl_valid),
        .cpl_ring(cpl_ring), .cpl_tag(cpl_tag), .cpl_ready(a_cready),
        .cq_wr_en(a_cqwe), .cq_wr_addr(a_cqaddr), .cq_wr_data(a_cqdata),
        .err_overflow(a_err)
    );
    cfa_rdport_model mem_a (.clk(clk), .rst_n(rst_n), .hold(hold),
        .req_valid(a_req), .req_addr(a_raddr), .rsp_valid(a_rsp), .rsp_data(a_rdata));

    cmd_fetch_arb #(.STARVE_LIMIT(0)) dut_nolimit_i (
        .clk(clk), .rst_n(rst_n), .db_wr_en(db_wr_en), .db_sel(db_sel),
        .db_value(db_value), .rd_req_valid(b_req), .rd_req_addr(b_raddr),
        .rd_rsp_valid(b_rsp), .rd_rsp_data(b_rdata), .cmd_valid(b_cmd),
        .cmd_data(b_cdata), .cmd_ring(b_ring), .cpl_valid(cpl_valid),
        .cpl_ring(cpl_ring), .cpl_tag(cpl_tag), .cpl_ready(b_cready),
        .cq_wr_en(b_cqwe), .cq_wr_addr(b_cqaddr), .cq_wr_data(b_cqdata),
        .err_overflow(b_err)
    );
    cfa_rdport_model mem_b (.clk(clk), .rst_n(rst_n), .hold(hold),
        .req_valid(b_req), .req_addr(b_raddr), .rsp_valid(b_rsp), .rsp_data(b_rdata));

    // logs gathered away from the active edge
    logic        la_ring [0:63];
    logic [31:0] la_data [0:63];
    logic        lb_ring [0:63];
    logic [31:0] lb_data [0:63];
    logic [15:0] lq_addr [0:31];
    logic [13:0] lq_data [0:31];
    int na = 0, nb = 0, nq = 0, pa = 0, pb = 0, r4_viol = 0;
    bit inflight = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (a_cmd && na < 64) begin la_ring[na] = a_ring; la_data[na] = a_cdata; na++; end
            if (b_cmd && nb < 64) begin lb_ring[nb] = b_ring; lb_data[nb] = b_cdata; nb++; end
            if (a_cqwe && nq < 32) begin lq_addr[nq] = a_cqaddr; lq_data[nq] = a_cqdata; nq++; end
            if (a_req && inflight) r4_viol++;
            if (a_req) inflight = 1'b1;
            else if (a_rsp) inflight = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_word(input bit ring, input int idx);
        logic [15:0] ad;
        ad = (ring ? TB : LB) + 16'(idx % 16);
        return {ad, ~ad};
    endfunction

    task automatic exp_a(input bit ring, input int idx, input string req);
        if (pa >= na) check(1'b0, req, 32'hDEAD, cmd_word(ring, idx));
        else check(la_ring[pa] == ring && la_data[pa] == cmd_word(ring, idx), req,
                   {la_data[pa][31:1], la_ring[pa]}, {cmd_word(ring, idx)[31:1], ring});
        pa++;
    endtask

    task automatic exp_b(input bit ring, input int idx, input string req);
        if (pb >= nb) check(1'b0, req, 32'hDEAD, cmd_word(ring, idx));
        else check(lb_ring[pb] == ring && lb_data[pb] == cmd_word(ring, idx), req,
                   {lb_data[pb][31:1], lb_ring[pb]}, {cmd_word(ring, idx)[31:1], ring});
        pb++;
    endtask

    task automatic ring_db(input logic [1:0] sel, input logic [3:0] val);
        @(negedge clk); db_wr_en = 1'b1; db_sel = sel; db_value = val;
        @(negedge clk); db_wr_en = 1'b0;
    endtask

    task automatic post(input bit ring, input logic [7:0] tag);
        @(negedge clk); cpl_valid = 1'b1; cpl_ring = ring; cpl_tag = tag;
        @(negedge clk); cpl_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle(4);
        // R1: reset state
        check(!a_req && !a_cmd && !a_cqwe && !a_err && a_cready, "R1",
              {27'd0, a_req, a_cmd, a_cqwe, a_err, a_cready}, 32'd1);
        rst_n = 1'b1;
        idle(2);
        check(!a_req && !a_cmd && !a_cqwe && !a_err && a_cready, "R1",
              {27'd0, a_req, a_cmd, a_cqwe, a_err, a_cready}, 32'd1);

        // R2: doorbell to request timing and address
        ring_db(2'd0, 4'd1);
        check(a_req == 1'b0, "R2", {31'd0, a_req}, 32'd0);
        @(negedge clk);
        check(a_req == 1'b1 && a_raddr == LB, "R2", {15'd0, a_req, a_raddr}, {16'd1, LB});
        @(negedge clk);
        check(a_req == 1'b0, "R2", {31'd0, a_req}, 32'd0);
        idle(10);
        exp_a(1'b0, 0, "R5");
        pb = 1;

        // R3: latency doorbell during a throughput read, then priority order
        ring_db(2'd1, 4'd3);
        ring_db(2'd0, 4'd4);
        idle(60);
        exp_a(1'b1, 0, "R3"); exp_a(1'b0, 1, "R3"); exp_a(1'b0, 2, "R3");
        exp_a(1'b0, 3, "R3"); exp_a(1'b1, 1, "R3"); exp_a(1'b1, 2, "R5");
        pb = 7;

        // R8 / R9: starvation limit on and off
        ring_db(2'd1, 4'd5);
        ring_db(2'd0, 4'd14);
        idle(100);
        exp_a(1'b1, 3, "R8");
        for (int i = 4; i < 8; i++) exp_a(1'b0, i, "R8");
        exp_a(1'b1, 4, "R8");
        for (int i = 8; i < 14; i++) exp_a(1'b0, i, "R8");
        exp_b(1'b1, 3, "R9");
        for (int i = 4; i < 14; i++) exp_b(1'b0, i, "R9");
        exp_b(1'b1, 4, "R9");

        // R7 / R6: fill a ring while reads are held, then overflow it
        hold = 1'b1;
        ring_db(2'd0, 4'd13);
        check(a_err == 1'b0, "R7", {31'd0, a_err}, 32'd0);
        ring_db(2'd0, 4'd14);
        check(a_err == 1'b1, "R6", {31'd0, a_err}, 32'd1);
        ring_db(2'd3, 4'd2);
        hold = 1'b0;
        idle(120);
        for (int i = 14; i < 29; i++) exp_a(1'b0, i, "R7");
        check(na == 34, "R6", 32'(na), 32'd34);
        check(a_err == 1'b1, "R6", {31'd0, a_err}, 32'd1);
        check(r4_viol == 0, "R4", 32'(r4_viol), 32'd0);

        // R10 / R11 / R12: completion ring
        for (int i = 0; i < 15; i++) post(i[0], 8'(i));
        idle(2);
        check(nq == 15, "R10", 32'(nq), 32'd15);
        for (int i = 0; i < 15; i++)
            check(lq_addr[i] == CB + 16'(i) &&
                  lq_data[i] == {1'b1, i[0], (i[0] ? 4'd5 : 4'd13), 8'(i)}, "R10",
                  {2'd0, lq_data[i], lq_addr[i]},
                  {2'd0, 1'b1, i[0], (i[0] ? 4'd5 : 4'd13), 8'(i), CB + 16'(i)});
        check(a_cready == 1'b0, "R12", {31'd0, a_cready}, 32'd0);
        post(1'b0, 8'hEE);
        idle(2);
        check(nq == 15, "R12", 32'(nq), 32'd15);
        ring_db(2'd2, 4'd8);
        check(a_cready == 1'b1, "R12", {31'd0, a_cready}, 32'd1);
        for (int j = 0; j < 8; j++) post(1'b1, 8'(16 + j));
        idle(2);
        check(nq == 23, "R12", 32'(nq), 32'd23);
        check(a_cready == 1'b0, "R12", {31'd0, a_cready}, 32'd0);
        for (int j = 0; j < 8; j++)
            check(lq_addr[15 + j] == CB + 16'((15 + j) % 16) &&
                  lq_data[15 + j][13] == (j == 0), "R11",
                  {15'd0, lq_data[15 + j][13], lq_addr[15 + j]},
                  {15'd0, (j == 0), CB + 16'((15 + j) % 16)});

        done = 1'b1;
        finish_run();
    end
endmodule